// File: doc/BRIEF.md
# Carrier NCO with Epoch-Latched Cycle and Phase Measurements

This block is the carrier numerically controlled oscillator of a single correlator channel. A 27-bit phase accumulator adds a programmable 26-bit increment on every clock. Each carry out of the accumulator marks one whole carrier cycle. The output frequency is the increment times the clock frequency divided by 2^27. An 18-bit counter totals the carries within each measurement epoch. The epoch boundary is a one-cycle `tic` strobe that comes from outside the block.

On each `tic` the block can capture two 16-bit measurement words. The cycle word holds the low 16 bits of the carry count. The phase word holds the top ten accumulator bits, so one LSB is 2π/1024 rad, and the two lowest count bits sit above them. A new-data flag guards both words. Once a capture has happened, later epochs leave the words alone until software reads the cycle word or pulses the clear input.

The increment is loaded with two bus writes. A write to the upper part is staged. A write to the lower part commits the whole 26-bit value, and a lower-part write on its own reuses the staged upper part. The committed value reaches the accumulator only at the next `tic`, so a change of frequency always lines up with an epoch boundary.

Top module: `carr_nco_meas`

## Requirements
- R1: The accumulator adds the active increment every clock, modulo 2^27. `cyc_pulse` is high in each cycle whose addition carries out of bit 26. The accumulator holds no more than one carry per cycle.
- R2: A write with `wr_addr`=1 stages `wr_data[9:0]` as increment bits 25..16. A write with `wr_addr`=0 commits {staged bits, `wr_data[15:0]`} as the pending increment. A lower-part write alone reuses the last staged upper part.
- R3: The pending increment becomes active only through a `tic`. The accumulator uses the new value from the cycle after the `tic` edge. Writes between epochs do not change the frequency.
- R4: The carry counter counts every carry. Its value in the `tic` cycle is the number of carries in the cycles from the previous `tic` cycle (inclusive) up to the current one (exclusive). Its low 16 bits form the cycle word. The counter then restarts, and a carry in the `tic` cycle counts toward the new epoch.
- R5: The phase word is laid out as follows. Bits 9..0 hold accumulator bits 26..17 as they stood during the `tic` cycle. Bits 11..10 hold bits 1..0 of the same count that went into the cycle word. Bits 15..12 read 0.
- R6: A `tic` while `new_meas` is 0 captures both words and sets `new_meas`. A `tic` while `new_meas` is 1 leaves both words unchanged.
- R7: A read of the cycle word (`rd_en`=1, `rd_sel`=0) or a `clr_new` pulse clears `new_meas`. If a capture happens in the same cycle, the capture wins and the flag stays set. A read of the phase word does not clear the flag.
- R8: A read request (`rd_sel`=0 cycle word, 1 phase word) places the selected word on `rd_data` one cycle later. The word returned is the value from before any capture in that same cycle. `rd_data` holds its value when `rd_en` is 0.
- R9: Synchronous reset clears the accumulator, the counter, all increment registers, both words, `rd_data` and `new_meas`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst | input | 1 | Synchronous active-high reset |
| tic | input | 1 | One-cycle epoch strobe |
| wr_en | input | 1 | Increment write strobe |
| wr_addr | input | 1 | 1 selects upper increment part, 0 lower (commits) |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Measurement read strobe |
| rd_sel | input | 1 | 0 cycle word, 1 phase word |
| clr_new | input | 1 | Clears the new-data flag |
| rd_data | output | 16 | Registered read data |
| new_meas | output | 1 | New-data flag / overwrite lock |
| cyc_pulse | output | 1 | Carrier cycle completed (accumulator carry) |

## Verification
The assertions assume that `rst` is held for at least one clock edge before use. They also assume that `wr_addr` and `rd_sel` are never unknown while their strobes are high. The bound "at most one carry per cycle" in R1 relies on the increment being narrower than the accumulator, which the parameters ensure. The epochs in the stimulus stay far shorter than 2^18 cycles, so the internal counter never wraps. The random phase keeps `tic` sparse enough that captures, locked epochs, clears and same-cycle read/capture collisions all occur. The directed part builds 1000-cycle epochs with known increments and checks the cycle count against the ideal N·I/2^27.

// File: rtl/carr_nco_pkg.sv
package carr_nco_pkg;

    localparam int P_ACC_W    = 27;
    localparam int P_INC_W    = 26;
    localparam int P_LO_W     = 16;
    localparam int P_CNT_W    = 18;
    localparam int P_WORD_W   = 16;
    localparam int P_PH_W     = 10;
    localparam int P_CYC_IN_PH = 2;

    typedef enum logic {
        WA_LO = 1'b0,
        WA_HI = 1'b1
    } wr_addr_e;

    typedef enum logic {
        RS_CYC = 1'b0,
        RS_PH  = 1'b1
    } rd_sel_e;

    typedef struct packed {
        logic [P_WORD_W-1:0] cyc;
        logic [P_WORD_W-1:0] ph;
    } meas_t;

    function automatic logic [P_WORD_W-1:0] pack_phase(
        input logic [P_PH_W-1:0]      top,
        input logic [P_CYC_IN_PH-1:0] cyc_lsb
    );
        return {{(P_WORD_W-P_PH_W-P_CYC_IN_PH){1'b0}}, cyc_lsb, top};
    endfunction

endpackage

// File: rtl/carr_incr_regs.sv
module carr_incr_regs
    import carr_nco_pkg::*;
#(
    parameter int INC_W = P_INC_W,
    parameter int LO_W  = P_LO_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tic,
    input  logic             wr_en,
    input  wr_addr_e         wr_addr,
    input  logic [LO_W-1:0]  wr_data,
    output logic [INC_W-1:0] incr_act
);
    localparam int HI_W = INC_W - LO_W;

    logic [HI_W-1:0]  hi_stage;
    logic [INC_W-1:0] incr_pend;
    logic             wr_lo;
    logic             wr_hi;

    assign wr_lo = wr_en && (wr_addr == WA_LO);
    assign wr_hi = wr_en && (wr_addr == WA_HI);

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_stage  <= '0;
            incr_pend <= '0;
            incr_act  <= '0;
        end else begin
            if (wr_hi) hi_stage  <= wr_data[HI_W-1:0];
            if (wr_lo) incr_pend <= {hi_stage, wr_data};
            if (tic)   incr_act  <= incr_pend;
        end
    end

    // R2: pending increment moves only on a lower-part write
    p_pend_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_lo |=> $stable(incr_pend))
        else $error("pending increment changed without lower write");

    // R3: active increment moves only on an epoch strobe
    p_act_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !tic |=> $stable(incr_act))
        else $error("active increment changed without tic");

endmodule

// File: rtl/carr_phase_acc.sv
module carr_phase_acc
    import carr_nco_pkg::*;
#(
    parameter int ACC_W = P_ACC_W,
    parameter int INC_W = P_INC_W,
    parameter int PH_W  = P_PH_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [INC_W-1:0] incr,
    output logic [PH_W-1:0]  acc_top,
    output logic             carry
);
    localparam int SUM_W = ACC_W + 1;

    logic [ACC_W-1:0] acc;
    logic [SUM_W-1:0] sum;

    assign sum     = {1'b0, acc} + SUM_W'(incr);
    assign carry   = sum[ACC_W];
    assign acc_top = acc[ACC_W-1 -: PH_W];

    always_ff @(posedge clk) begin
        if (rst) acc <= '0;
        else     acc <= sum[ACC_W-1:0];
    end

    // R1: a carry means the accumulator wrapped downward
    p_wrap_carry_r1: assert property (@(posedge clk) disable iff (rst)
        carry |=> (acc < $past(acc)))
        else $error("carry without wrap");

    // R1: no carry means the accumulator did not decrease
    p_no_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        !carry |=> (acc >= $past(acc)))
        else $error("wrap without carry");

endmodule

// File: rtl/carr_cycle_cnt.sv
module carr_cycle_cnt
    import carr_nco_pkg::*;
#(
    parameter int CNT_W = P_CNT_W,
    parameter int OUT_W = P_WORD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tic,
    input  logic             carry,
    output logic [OUT_W-1:0] cnt_lo
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)      cnt <= '0;
        else if (tic) cnt <= CNT_W'(carry);
        else          cnt <= cnt + CNT_W'(carry);
    end

    assign cnt_lo = cnt[OUT_W-1:0];

    // R4: counter restarts on the epoch strobe, keeping only that cycle's carry
    p_cnt_restart_r4: assert property (@(posedge clk) disable iff (rst)
        tic |=> (cnt == CNT_W'($past(carry))))
        else $error("counter did not restart on tic");

    // R4: between epochs the counter advances by the carry
    p_cnt_step_r4: assert property (@(posedge clk) disable iff (rst)
        !tic |=> (cnt == $past(cnt) + CNT_W'($past(carry))))
        else $error("counter skipped or lost a carry");

endmodule

// File: rtl/carr_meas_bank.sv
module carr_meas_bank
    import carr_nco_pkg::*;
#(
    parameter int WORD_W = P_WORD_W,
    parameter int PH_W   = P_PH_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tic,
    input  logic [WORD_W-1:0] cnt_lo,
    input  logic [PH_W-1:0]   acc_top,
    input  logic              rd_en,
    input  rd_sel_e           rd_sel,
    input  logic              clr_new,
    output logic [WORD_W-1:0] rd_data,
    output logic              new_meas
);
    meas_t words;
    logic  capture;
    logic  rd_cyc;
    logic  unlock;

    assign capture = tic && !new_meas;
    assign rd_cyc  = rd_en && (rd_sel == RS_CYC);
    assign unlock  = rd_cyc || clr_new;

    always_ff @(posedge clk) begin
        if (rst) begin
            words    <= '0;
            rd_data  <= '0;
            new_meas <= 1'b0;
        end else begin
            if (capture) begin
                words.cyc <= cnt_lo;
                words.ph  <= pack_phase(acc_top, cnt_lo[P_CYC_IN_PH-1:0]);
            end
            if (rd_en)
                rd_data <= (rd_sel == RS_PH) ? words.ph : words.cyc;
            if (capture)     new_meas <= 1'b1;
            else if (unlock) new_meas <= 1'b0;
        end
    end

    // R5: the two cycle bits in the phase word agree with the cycle word
    p_ph_cyc_agree_r5: assert property (@(posedge clk) disable iff (rst)
        capture |=> (words.ph[PH_W +: P_CYC_IN_PH] == words.cyc[P_CYC_IN_PH-1:0]))
        else $error("phase word cycle bits disagree");

    // R6: locked epochs keep both words
    p_locked_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (tic && new_meas) |=> ($stable(words.cyc) && $stable(words.ph)))
        else $error("locked measurement overwritten");

    // R6: a capture raises the flag
    p_flag_set_r6: assert property (@(posedge clk) disable iff (rst)
        (tic && !new_meas) |=> new_meas)
        else $error("flag not set on capture");

    // R7: cycle read or clear drops the flag when no capture collides
    p_flag_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (!tic && unlock) |=> !new_meas)
        else $error("flag not cleared");

    // R8: read data holds without a read strobe
    p_rd_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data))
        else $error("read data changed without read");

    // R9: reset leaves the flag and read data cleared
    p_reset_r9: assert property (@(posedge clk)
        rst |=> (!new_meas && (rd_data == '0)))
        else $error("reset state wrong");

endmodule

// File: rtl/carr_nco_meas.sv
module carr_nco_meas
    import carr_nco_pkg::*;
#(
    parameter int ACC_W  = P_ACC_W,
    parameter int INC_W  = P_INC_W,
    parameter int LO_W   = P_LO_W,
    parameter int CNT_W  = P_CNT_W,
    parameter int WORD_W = P_WORD_W,
    parameter int PH_W   = P_PH_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tic,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [LO_W-1:0]   wr_data,
    input  logic              rd_en,
    input  logic              rd_sel,
    input  logic              clr_new,
    output logic [WORD_W-1:0] rd_data,
    output logic              new_meas,
    output logic              cyc_pulse
);
    logic [INC_W-1:0]  incr_act;
    logic [PH_W-1:0]   acc_top;
    logic              carry;
    logic [WORD_W-1:0] cnt_lo;

    carr_incr_regs #(.INC_W(INC_W), .LO_W(LO_W)) u_incr (
        .clk      (clk),
        .rst      (rst),
        .tic      (tic),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr_e'(wr_addr)),
        .wr_data  (wr_data),
        .incr_act (incr_act)
    );

    carr_phase_acc #(.ACC_W(ACC_W), .INC_W(INC_W), .PH_W(PH_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .incr    (incr_act),
        .acc_top (acc_top),
        .carry   (carry)
    );

    carr_cycle_cnt #(.CNT_W(CNT_W), .OUT_W(WORD_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .tic    (tic),
        .carry  (carry),
        .cnt_lo (cnt_lo)
    );

    carr_meas_bank #(.WORD_W(WORD_W), .PH_W(PH_W)) u_meas (
        .clk      (clk),
        .rst      (rst),
        .tic      (tic),
        .cnt_lo   (cnt_lo),
        .acc_top  (acc_top),
        .rd_en    (rd_en),
        .rd_sel   (rd_sel_e'(rd_sel)),
        .clr_new  (clr_new),
        .rd_data  (rd_data),
        .new_meas (new_meas)
    );

    assign cyc_pulse = carry;

endmodule

// File: tb/carr_nco_meas_tb.sv
`timescale 1ns/1ps
module carr_nco_meas_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tic = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic        rd_sel = 1'b0;
    logic        clr_new = 1'b0;
    logic [15:0] rd_data;
    logic        new_meas;
    logic        cyc_pulse;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    longint unsigned cyc_no = 0;

    always #2.5 clk = ~clk;

    carr_nco_meas u_dut (
        .clk(clk), .rst(rst), .tic(tic), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_sel(rd_sel), .clr_new(clr_new),
        .rd_data(rd_data), .new_meas(new_meas), .cyc_pulse(cyc_pulse)
    );

    // reference state built from the requirements
    longint unsigned m_acc, m_act, m_pend, m_hi, m_cnt;
    logic [15:0] m_cyc, m_ph, m_rd;
    bit m_flag;

    function automatic bit ref_carry(longint unsigned a, longint unsigned i);
        return ((a + i) >> 27) & 1;
    endfunction

    function automatic longint unsigned ideal_floor(longint unsigned n, longint unsigned i);
        return (n * i) >> 27;
    endfunction

    always @(posedge clk) begin
        longint unsigned sum;
        bit ovf, cap;
        cyc_no++;
        if (rst) begin
            m_acc = 0; m_act = 0; m_pend = 0; m_hi = 0; m_cnt = 0;
            m_cyc = '0; m_ph = '0; m_rd = '0; m_flag = 0;
        end else begin
            sum = m_acc + m_act;
            ovf = ref_carry(m_acc, m_act);
            cap = tic && !m_flag;
            if (rd_en) m_rd = rd_sel ? m_ph : m_cyc;
            if (cap) begin
                m_cyc = m_cnt[15:0];
                m_ph  = {4'b0, m_cnt[1:0], 10'((m_acc >> 17) & 64'h3FF)};
            end
            if (cap) m_flag = 1;
            else if (clr_new || (rd_en && !rd_sel)) m_flag = 0;
            m_cnt = tic ? longint'(ovf) : m_cnt + longint'(ovf);
            m_acc = sum & 64'h7FF_FFFF;
            if (tic) m_act = m_pend;
            if (wr_en && !wr_addr) m_pend = (m_hi << 16) | longint'(wr_data);
            if (wr_en && wr_addr) m_hi = longint'(wr_data) & 64'h3FF;
        end
    end

    task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_rng(input string tag, input longint unsigned act,
                           input longint unsigned lo, input longint unsigned hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
        end
    endtask

    // continuous comparison against the reference, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R1 cyc_pulse", longint'(cyc_pulse), longint'(ref_carry(m_acc, m_act)));
            chk("R6 new_meas", longint'(new_meas), longint'(m_flag));
            chk("R8 rd_data", longint'(rd_data), longint'(m_rd));
        end
    end

    task automatic strobes_off();
        tic = 0; wr_en = 0; rd_en = 0; clr_new = 0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); strobes_off();
        end
    endtask

    task automatic wr(input bit hi, input logic [15:0] d);
        @(negedge clk); strobes_off();
        wr_en = 1; wr_addr = hi; wr_data = d;
    endtask

    task automatic pulse_tic(output longint unsigned when);
        @(negedge clk); strobes_off();
        tic = 1; when = cyc_no;
    endtask

    task automatic rd(input bit sel, output logic [15:0] v);
        @(negedge clk); strobes_off();
        rd_en = 1; rd_sel = sel;
        @(negedge clk); strobes_off();
        v = rd_data;
    endtask

    task automatic pulse_clr();
        @(negedge clk); strobes_off();
        clr_new = 1;
    endtask

    // one epoch of exactly 1000 cycles, returns the captured cycle word
    task automatic epoch_1000(output logic [15:0] cw);
        longint unsigned ta, tb_;
        logic [15:0] v;
        pulse_tic(ta);
        rd(0, v);          // unlock after capture at the first tic
        idle(997);
        pulse_tic(tb_);
        rd(0, cw);
        chk("R4 epoch length", tb_ - ta, 1000);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, v2, ph_saved, cyc_saved;
        longint unsigned t;
        void'($urandom(32'd1234));

        // reset
        rst = 1; strobes_off();
        repeat (3) @(negedge clk);
        chk("R9 reset rd_data", longint'(rd_data), 0);
        chk("R9 reset new_meas", longint'(new_meas), 0);
        chk("R9 reset cyc_pulse", longint'(cyc_pulse), 0);
        rst = 0;

        // nominal increment: staged, not yet active
        wr(1, 16'h01F7);
        wr(0, 16'hB1B9);
        idle(4);
        chk("R3 no carry before tic", longint'(cyc_pulse), 0);
        chk("R3 pending not active", longint'(u_dut.cyc_pulse), 0);

        pulse_tic(t);   // activates increment, captures empty epoch
        idle(1);
        chk("R6 flag after first capture", longint'(new_meas), 1);
        rd(0, v);
        chk("R4 first epoch count", longint'(v), 0);
        chk("R7 cycle read clears flag", longint'(new_meas), 0);

        // full 1000-cycle epoch with the nominal increment
        epoch_1000(v);
        chk_rng("R4 nominal count", longint'(v),
                ideal_floor(1000, 64'h1F7B1B9), ideal_floor(1000, 64'h1F7B1B9) + 1);

        // lock: capture, then a locked tic, words must stay
        pulse_tic(t);
        rd(1, ph_saved);
        chk("R5 phase top bits zero", longint'(ph_saved[15:12]), 0);
        chk("R7 phase read keeps flag", longint'(new_meas), 1);
        idle(37);
        pulse_tic(t);
        idle(2);
        rd(1, v2);
        chk("R6 locked phase kept", longint'(v2), longint'(ph_saved));
        rd(0, cyc_saved);
        chk("R5 cycle bits in phase", longint'(ph_saved[11:10]), longint'(cyc_saved[1:0]));

        // explicit clear
        pulse_tic(t);
        idle(1);
        chk("R6 captured again", longint'(new_meas), 1);
        pulse_clr();
        idle(1);
        chk("R7 clear drops flag", longint'(new_meas), 0);

        // lower-only write reuses staged upper part 0x1F7
        wr(0, 16'h0000);
        pulse_tic(t);      // activates 0x1F70000
        rd(0, v);
        epoch_1000(v);
        chk_rng("R2 lower-only write count", longint'(v),
                ideal_floor(1000, 64'h1F70000), ideal_floor(1000, 64'h1F70000) + 1);

        // capture and cycle read in the same cycle: capture wins, old data returned
        @(negedge clk); strobes_off();
        tic = 1; rd_en = 1; rd_sel = 0;
        @(negedge clk); strobes_off();
        chk("R7 capture beats clear", longint'(new_meas), 1);
        chk("R8 old word on collision", longint'(rd_data), longint'(v));

        // maximum increment
        wr(1, 16'h03FF);
        wr(0, 16'hFFFF);
        pulse_clr();
        pulse_tic(t);
        rd(0, v);
        epoch_1000(v);
        chk_rng("R1 max increment count", longint'(v),
                ideal_floor(1000, 64'h3FFFFFF), ideal_floor(1000, 64'h3FFFFFF) + 1);

        // constrained random traffic
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk); strobes_off();
            tic     = ($urandom % 40) == 0;
            wr_en   = ($urandom % 15) == 0;
            wr_addr = $urandom % 2;
            wr_data = 16'($urandom);
            rd_en   = ($urandom % 6) == 0;
            rd_sel  = $urandom % 2;
            clr_new = ($urandom % 50) == 0;
        end
        idle(3);

        // reset again mid-run
        @(negedge clk); strobes_off(); rst = 1;
        @(negedge clk); rst = 0;
        chk("R9 reset flag", longint'(new_meas), 0);
        chk("R9 reset read data", longint'(rd_data), 0);
        chk("R9 reset carry", longint'(cyc_pulse), 0);
        idle(2);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule